// File: doc/BRIEF.md
# Streaming Flat-Field Pixel Corrector

This block sits at the head of a camera pixel pipeline. It takes one raw sensor sample per clock, and with each sample it takes that pixel's own calibration word: a dark-level offset, a gain factor and a defect flag. A fetch path outside the block supplies these words already aligned to the pixel.

For a healthy pixel, the block first removes the dark level. It clips that difference at zero, scales it by the gain and limits the result to the pixel range. When every pixel's factors are calibrated, a scene that is evenly lit at any brightness gives one flat output value across the frame.

A pixel flagged as defective does not take its own corrected value. It is rebuilt from the corrected values of the nearest pixels of the same colour, two places to its left and two to its right on the same line.

The valid, start-of-frame and end-of-line markers travel with the data and leave the block after a fixed delay. Within one line, pixels must arrive on consecutive clocks. Idle clocks are allowed only between lines.

Top module: `flatfield_corrector`

## Requirements
- R1: For a pixel with `in_dead`=0, the output is min(2^PW−1, ((raw−offset) × gain) >> 15), where `in_gain` is unsigned with 1 integer bit and 15 fraction bits (bits 14:0 are the fraction).
- R2: A non-defective pixel whose raw value is less than or equal to its offset outputs 0.
- R3: A non-defective pixel whose scaled value exceeds 2^PW−1 outputs exactly 2^PW−1.
- R4: With gain 0x8000 (unity) and offset 0, a non-defective pixel leaves unchanged.
- R5: A pixel with `in_dead`=1 whose pixels at −2 and +2 on the same line both exist and are not flagged outputs floor((L+R)/2), where L and R are the R1 values of those two neighbours.
- R6: A flagged pixel with exactly one usable neighbour at ±2 outputs that neighbour's R1 value. A neighbour is unusable when it lies outside the line or is itself flagged.
- R7: A flagged pixel with no usable neighbour at ±2 outputs its own R1 value.
- R8: Each pixel sampled with `in_valid`=1 at a clock edge appears with `out_valid`=1 exactly 4 clock edges later. `out_valid` is 0 in every other cycle.
- R9: `out_sof` and `out_eol` equal the `in_sof` and `in_eol` of the accepted pixel they leave with, and are 0 when `out_valid` is 0.
- R10: While `rst_n` is low, and in the first cycle after it is released, `out_valid`, `out_sof` and `out_eol` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Raw pixel and its calibration word are present |
| in_sof | input | 1 | First pixel of a frame |
| in_eol | input | 1 | Last pixel of a line |
| in_dead | input | 1 | Pixel is marked defective in the defect map |
| in_pix | input | PW | Raw sensor sample |
| in_offs | input | PW | Dark-level offset for this pixel |
| in_gain | input | 16 | Gain for this pixel, unsigned 1.15 |
| out_valid | output | 1 | Corrected pixel present |
| out_sof | output | 1 | Start-of-frame marker, delayed with the pixel |
| out_eol | output | 1 | End-of-line marker, delayed with the pixel |
| out_pix | output | PW | Corrected pixel |

## Verification
Most internal faults show up at the ports within one latency window.
- A wrong offset or gain register in the scaling stages gives a wrong value on the very next healthy pixel. That value comes out 4 cycles after the pixel goes in.
- A slip in the neighbour window is different. It only shows on a defective pixel, as a wrong average, or as a neighbour taken from across a line boundary. The bench therefore places flags at line edges, next to other flags, and on lines of one to three pixels.
- A marker or valid register that falls out of step shifts `out_valid` or `out_eol` against the data at once. It therefore breaks the cycle stamp the scoreboard keeps for every pixel.

// File: rtl/ffc_pkg.sv
package ffc_pkg;
  // Per-pixel side-band that travels beside the data through every stage
  typedef struct packed {
    logic v;
    logic sof;
    logic eol;
    logic dead;
  } ffc_tag_t;
endpackage

// File: rtl/ffc_gain_mac.sv
// Two-stage offset subtract and gain scale with saturation
module ffc_gain_mac
  import ffc_pkg::*;
#(
  parameter int PW = 12,
  parameter int GW = 16,
  parameter int GF = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ffc_tag_t      tag_i,
  input  logic [PW-1:0] raw_i,
  input  logic [PW-1:0] offs_i,
  input  logic [GW-1:0] gain_i,
  output ffc_tag_t      tag_o,
  output logic [PW-1:0] cor_o
);
  localparam int PRW = PW + GW;
  localparam int SW  = PRW - GF;

  ffc_tag_t      s1_tag, s2_tag;
  logic [PW-1:0] s1_diff, s1_diff_n;
  logic [GW-1:0] s1_gain;
  logic [PW-1:0] s2_cor, s2_cor_n;
  logic [PRW-1:0] prod;
  logic [SW-1:0]  scaled;

  always_comb begin
    s1_diff_n = (raw_i > offs_i) ? (raw_i - offs_i) : '0;
  end

  always_comb begin
    prod     = {{GW{1'b0}}, s1_diff} * {{PW{1'b0}}, s1_gain};
    scaled   = prod[PRW-1:GF];
    s2_cor_n = (|scaled[SW-1:PW]) ? {PW{1'b1}} : scaled[PW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_tag <= '0;
      s2_tag <= '0;
    end else begin
      s1_tag <= tag_i;
      s2_tag <= s1_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (tag_i.v) begin
      s1_diff <= s1_diff_n;
      s1_gain <= gain_i;
    end
    if (s1_tag.v) begin
      s2_cor <= s2_cor_n;
    end
  end

  assign tag_o = s2_tag;
  assign cor_o = s2_cor;
endmodule

// File: rtl/ffc_dead_fill.sv
// Neighbour window and defective-pixel substitution
module ffc_dead_fill
  import ffc_pkg::*;
#(
  parameter int PW     = 12,
  parameter int STRIDE = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ffc_tag_t      tag_i,
  input  logic [PW-1:0] pix_i,
  output logic          v_o,
  output logic          sof_o,
  output logic          eol_o,
  output logic [PW-1:0] pix_o
);
  localparam int TAPS = 2 * STRIDE + 1;
  localparam int CTR  = STRIDE;
  localparam int LFT  = TAPS - 1;

  ffc_tag_t      ht_q [1:TAPS-1];
  logic [PW-1:0] hp_q [1:TAPS-1];
  ffc_tag_t      wt   [TAPS];
  logic [PW-1:0] wp   [TAPS];
  logic          left_ok, right_ok;
  logic [PW:0]   pair_sum;
  logic [PW-1:0] pix_n;

  // tap 0 is the newest corrected pixel, tap LFT the oldest
  always_comb begin
    wt[0] = tag_i;
    wp[0] = pix_i;
    for (int k = 1; k < TAPS; k++) begin
      wt[k] = ht_q[k];
      wp[k] = hp_q[k];
    end
  end

  always_comb begin
    left_ok  = wt[LFT].v & ~wt[LFT].dead;
    right_ok = wt[0].v & ~wt[0].dead;
    for (int k = CTR + 1; k < TAPS; k++) left_ok  = left_ok & wt[k].v & ~wt[k].eol;
    for (int k = CTR; k < TAPS - 1; k++) left_ok  = left_ok & ~wt[k].sof;
    for (int k = 0; k < CTR; k++)        right_ok = right_ok & wt[k].v & ~wt[k].sof;
    for (int k = 1; k <= CTR; k++)       right_ok = right_ok & ~wt[k].eol;
  end

  always_comb begin
    pair_sum = {1'b0, wp[LFT]} + {1'b0, wp[0]};
    if (!wt[CTR].dead)           pix_n = wp[CTR];
    else if (left_ok && right_ok) pix_n = pair_sum[PW:1];
    else if (left_ok)            pix_n = wp[LFT];
    else if (right_ok)           pix_n = wp[0];
    else                         pix_n = wp[CTR];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 1; k < TAPS; k++) ht_q[k] <= '0;
      v_o   <= 1'b0;
      sof_o <= 1'b0;
      eol_o <= 1'b0;
    end else begin
      for (int k = 1; k < TAPS; k++) ht_q[k] <= wt[k-1];
      v_o   <= wt[CTR].v;
      sof_o <= wt[CTR].v & wt[CTR].sof;
      eol_o <= wt[CTR].v & wt[CTR].eol;
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 1; k < TAPS; k++) hp_q[k] <= wp[k-1];
    if (wt[CTR].v) pix_o <= pix_n;
  end
endmodule

// File: rtl/flatfield_corrector.sv
module flatfield_corrector
  import ffc_pkg::*;
#(
  parameter int PW     = 12,
  parameter int GW     = 16,
  parameter int GF     = 15,
  parameter int STRIDE = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic          in_eol,
  input  logic          in_dead,
  input  logic [PW-1:0] in_pix,
  input  logic [PW-1:0] in_offs,
  input  logic [GW-1:0] in_gain,
  output logic          out_valid,
  output logic          out_sof,
  output logic          out_eol,
  output logic [PW-1:0] out_pix
);
  ffc_tag_t      in_tag, mac_tag;
  logic [PW-1:0] mac_pix;

  assign in_tag = '{v: in_valid, sof: in_sof, eol: in_eol, dead: in_dead};

  ffc_gain_mac #(.PW(PW), .GW(GW), .GF(GF)) u_mac (
    .clk    (clk),
    .rst_n  (rst_n),
    .tag_i  (in_tag),
    .raw_i  (in_pix),
    .offs_i (in_offs),
    .gain_i (in_gain),
    .tag_o  (mac_tag),
    .cor_o  (mac_pix)
  );

  ffc_dead_fill #(.PW(PW), .STRIDE(STRIDE)) u_fill (
    .clk   (clk),
    .rst_n (rst_n),
    .tag_i (mac_tag),
    .pix_i (mac_pix),
    .v_o   (out_valid),
    .sof_o (out_sof),
    .eol_o (out_eol),
    .pix_o (out_pix)
  );
endmodule

// File: rtl/ffc_checker.sv
module ffc_checker #(
  parameter int PW     = 12,
  parameter int GW     = 16,
  parameter int GF     = 15,
  parameter int STRIDE = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_sof,
  input logic          in_eol,
  input logic          in_dead,
  input logic [PW-1:0] in_pix,
  input logic [PW-1:0] in_offs,
  input logic [GW-1:0] in_gain,
  input logic          out_valid,
  input logic          out_sof,
  input logic          out_eol,
  input logic [PW-1:0] out_pix
);
  // sampled output lags the sampled input by latency + 1 edges
  localparam int D = 2 + STRIDE + 1;
  localparam longint PMAX = (longint'(1) << PW) - 1;

  function automatic logic [PW-1:0] expect_pix(logic [PW-1:0] r, logic [PW-1:0] o,
                                               logic [GW-1:0] g);
    longint p;
    if (r <= o) return '0;
    p = (longint'(r) - longint'(o)) * longint'(g);
    p = p >> GF;
    if (p > PMAX) return {PW{1'b1}};
    return p[PW-1:0];
  endfunction

  // R8
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid, D));

  // R9
  marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sof == $past(in_valid && in_sof, D)) && (out_eol == $past(in_valid && in_eol, D)));

  // R1
  corr_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(in_dead, D)) |->
      out_pix == expect_pix($past(in_pix, D), $past(in_offs, D), $past(in_gain, D)));

  // R2
  dark_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(in_dead, D) && $past(in_pix <= in_offs, D)) |-> out_pix == '0);

  // R10
  idle_after_reset_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (!out_valid && !out_sof && !out_eol));
endmodule

bind flatfield_corrector ffc_checker #(.PW(PW), .GW(GW), .GF(GF), .STRIDE(STRIDE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_sof    (in_sof),
  .in_eol    (in_eol),
  .in_dead   (in_dead),
  .in_pix    (in_pix),
  .in_offs   (in_offs),
  .in_gain   (in_gain),
  .out_valid (out_valid),
  .out_sof   (out_sof),
  .out_eol   (out_eol),
  .out_pix   (out_pix)
);

// File: tb/tb_flatfield_corrector.sv
module tb_flatfield_corrector;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 12;
  localparam int MAXV = (1 << PW) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_sof, in_eol, in_dead;
  logic [PW-1:0] in_pix, in_offs;
  logic [15:0] in_gain;
  logic out_valid, out_sof, out_eol;
  logic [PW-1:0] out_pix;

  always #(CLK_PERIOD/2) clk = ~clk;

  flatfield_corrector dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_eol(in_eol),
    .in_dead(in_dead), .in_pix(in_pix), .in_offs(in_offs), .in_gain(in_gain),
    .out_valid(out_valid), .out_sof(out_sof), .out_eol(out_eol), .out_pix(out_pix)
  );

  typedef struct {
    int    pix;
    bit    sof;
    bit    eol;
    int    cyc;
    string req;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  int lr[16], lo[16], lg[16];
  bit ld[16];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int model(int r, int o, int g);
    int p;
    if (r <= o) return 0;
    p = ((r - o) * g) >>> 15;
    return (p > MAXV) ? MAXV : p;
  endfunction

  task automatic send_line(input int n, input bit sof);
    int c[16];
    int e[16];
    string t[16];
    for (int i = 0; i < n; i++) c[i] = model(lr[i], lo[i], lg[i]);
    for (int i = 0; i < n; i++) begin
      bit lok, rok;
      lok = (i >= 2) && !ld[i-2];
      rok = (i + 2 < n) && !ld[i+2];
      if (!ld[i]) begin
        e[i] = c[i];
        if (lr[i] <= lo[i]) t[i] = "R2";
        else if (((lr[i] - lo[i]) * lg[i]) >>> 15 > MAXV) t[i] = "R3";
        else if (lg[i] == 32768 && lo[i] == 0) t[i] = "R4";
        else t[i] = "R1";
      end else if (lok && rok) begin
        e[i] = (c[i-2] + c[i+2]) / 2; t[i] = "R5";
      end else if (lok) begin
        e[i] = c[i-2]; t[i] = "R6";
      end else if (rok) begin
        e[i] = c[i+2]; t[i] = "R6";
      end else begin
        e[i] = c[i]; t[i] = "R7";
      end
    end
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_sof   = sof && (i == 0);
      in_eol   = (i == n - 1);
      in_dead  = ld[i];
      in_pix   = PW'(lr[i]);
      in_offs  = PW'(lo[i]);
      in_gain  = 16'(lg[i]);
      q.push_back('{e[i], sof && (i == 0), i == n - 1, cyc + 5, t[i]});
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0; in_dead = 1'b0;
    end
  endtask

  task automatic clear_line();
    for (int i = 0; i < 16; i++) begin
      lr[i] = 0; lo[i] = 0; lg[i] = 32768; ld[i] = 1'b0;
    end
  endtask

  // monitor: pops one expected item per output pixel
  always @(negedge clk) begin
    if (rst_n && !done && out_valid) begin
      checks++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL R8: unexpected out_valid at cycle %0d, got pix %0d, expected no output", cyc, out_pix);
      end else begin
        exp_t x;
        x = q.pop_front();
        if (int'(out_pix) != x.pix) begin
          fails++;
          $display("FAIL %s: pix got %0d expected %0d", x.req, out_pix, x.pix);
        end
        if (cyc != x.cyc) begin
          fails++;
          $display("FAIL R8: output cycle got %0d expected %0d", cyc, x.cyc);
        end
        if (out_sof != x.sof || out_eol != x.eol) begin
          fails++;
          $display("FAIL R9: sof/eol got %0b/%0b expected %0b/%0b", out_sof, out_eol, x.sof, x.eol);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run still busy at cycle %0d, expected to finish", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int seed;
    rst_n = 1'b0;
    in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0; in_dead = 1'b0;
    in_pix = '0; in_offs = '0; in_gain = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid || out_sof || out_eol) begin
      fails++;
      $display("FAIL R10: in reset got v/sof/eol %0b%0b%0b expected 000", out_valid, out_sof, out_eol);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid || out_sof || out_eol) begin
      fails++;
      $display("FAIL R10: after release got v/sof/eol %0b%0b%0b expected 000", out_valid, out_sof, out_eol);
    end

    // R4: unity gain, zero offset
    clear_line();
    for (int i = 0; i < 8; i++) lr[i] = i * 500 + 7;
    send_line(8, 1'b1);

    // R1 R2 R3 mix, back to back with the previous line
    clear_line();
    lr[0] = 100;  lo[0] = 200; lg[0] = 40000;
    lr[1] = 200;  lo[1] = 200; lg[1] = 65535;
    lr[2] = 4000; lo[2] = 0;   lg[2] = 65535;
    lr[3] = 1000; lo[3] = 40;  lg[3] = 49152;
    lr[4] = 3000; lo[4] = 100; lg[4] = 20000;
    lr[5] = 4095; lo[5] = 0;   lg[5] = 32769;
    send_line(6, 1'b0);
    idle(3);

    // R5 R6 R7: flags at edges, middle, and next to each other
    clear_line();
    for (int i = 0; i < 10; i++) begin
      lr[i] = 100 * (i + 1) + 3 * i; lo[i] = 10;
    end
    ld[0] = 1'b1; ld[4] = 1'b1; ld[7] = 1'b1; ld[9] = 1'b1;
    send_line(10, 1'b0);
    // short lines directly after, so neighbours must not cross line edges
    clear_line();
    lr[0] = 900; lr[1] = 50; lr[2] = 700; ld[1] = 1'b1;
    send_line(3, 1'b0);
    clear_line();
    lr[0] = 1234; lo[0] = 34; ld[0] = 1'b1;
    send_line(1, 1'b0);
    clear_line();
    lr[0] = 10; lr[1] = 20; lr[2] = 30; lr[3] = 40; ld[2] = 1'b1;
    send_line(4, 1'b0);
    idle(2);

    // new frame with pseudo-random pixels and flags
    seed = 32'h1d3;
    for (int ln = 0; ln < 4; ln++) begin
      clear_line();
      for (int i = 0; i < 12; i++) begin
        seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
        lr[i] = (seed >>> 4) & MAXV;
        lo[i] = (seed >>> 17) & 255;
        lg[i] = 24576 + ((seed >>> 8) & 32767);
        ld[i] = ((seed >>> 3) & 7) == 0;
      end
      send_line(12, ln == 0);
      if (ln[0]) idle(1);
    end
    idle(10);

    done = 1'b1;
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R8: %0d pixels never emerged, expected 0", q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule